// File: doc/BRIEF.md
# Autonegotiation Link Timer

This block times the autonegotiation link interval of a gigabit serial Ethernet PCS. The core clock feeds a free-running 10-bit prescaler, so one timer tick is 1024 clock cycles. A tick counter then runs up to a limit, and when it reaches that limit the block gives a single-cycle expiry pulse. The autonegotiation state machine that owns the timer pulses `start_i` to arm or re-arm it. It watches `running_o` and `expire_o` to track the interval.

The limit is either a value that software has written or a default built into the block. The default comes from the interface mode and the core clock frequency. It is the interval in microseconds times the clock in MHz, shifted right by the prescaler width. The 1000BASE-X interval is 10 ms and the SGMII interval is 1.6 ms. The limit and the mode are both captured only at a start, so changing either one during a run leaves that run unchanged.

Top module: `an_link_timer`

## Requirements
- R1: While `rst_ni` is low and after it is released, `expire_o` and `running_o` are 0 until the first start. After reset the default limit is selected.
- R2: With the default limit selected and `mode_i`=1 (1000BASE-X) at the start, the limit is (10000·CLK_MHZ)>>10 ticks.
- R3: With the default limit selected and `mode_i`=0 (SGMII) at the start, the limit is (1600·CLK_MHZ)>>10 ticks.
- R4: One tick is 1024 cycles. For a limit N≥1, `expire_o` is high in the cycle that follows clock edge 1024·N, counting from the edge that samples `start_i` as edge 0.
- R5: A sampled `start_i` clears the prescaler and the tick counter, and `running_o` is 1 from the next cycle on.
- R6: `expire_o` stays high for exactly one cycle. `running_o` falls at the same edge, and no further expiry occurs until the next start.
- R7: A limit of 0 expires on the first tick, 1024 cycles after the start, which is the same timing as a limit of 1.
- R8: A write of `cnt_wdata_i` and a change of `mode_i` during a run leave the current run unchanged. They take effect at the next start.
- R9: A pulse on `cnt_wr_i` stores `cnt_wdata_i` and selects it as the limit. A pulse on `dflt_sel_i` selects the mode default again. When both are high on the same edge, the write wins.
- R10: A start on the same edge that would otherwise expire restarts the timer. No pulse is given, and the new run takes a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 = 1000BASE-X interval, 0 = SGMII interval |
| cnt_wr_i | input | 1 | Stores `cnt_wdata_i` as the user limit |
| cnt_wdata_i | input | CNT_W | User limit, in units of 1024 cycles |
| dflt_sel_i | input | 1 | Selects the mode default limit again |
| start_i | input | 1 | Arms or re-arms the timer |
| expire_o | output | 1 | One-cycle pulse when the interval ends |
| running_o | output | 1 | High while an interval is being timed |

## Verification
On every cycle, the assertions check that expiry lands only on a multiple of 1024 cycles after the last start. They also check that the pulse lasts one cycle, that `running_o` falls with the pulse and stays low until a start, and that a start always gives a running timer with no pulse one cycle later. Some behaviour is not visible in those local relations: which number of ticks is used (the mode default, a written value, zero), that a mid-run write or mode change is held off, and that write beats default select. Only the bench scenarios can show these, through a behavioural reference model compared on every clock.

// File: rtl/an_tmr_pkg.sv
package an_tmr_pkg;
  typedef enum logic {
    MODE_SGMII = 1'b0,
    MODE_BASEX = 1'b1
  } an_mode_e;

  localparam int unsigned BASEX_US = 10000;
  localparam int unsigned SGMII_US = 1600;

  // interval [us] * clock [MHz] gives cycles; shift converts to prescaled ticks
  function automatic longint unsigned dflt_ticks(input int unsigned us,
                                                 input int unsigned mhz,
                                                 input int unsigned shift);
    longint unsigned cyc;
    cyc = longint'(us) * longint'(mhz);
    return cyc >> shift;
  endfunction
endpackage

// File: rtl/an_tmr_prescale.sv
module an_tmr_prescale #(
  parameter int unsigned PRE_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + PRE_W'(1);
  end

  assign tick_o = &cnt_q;
endmodule

// File: rtl/an_tmr_limit.sv
module an_tmr_limit
  import an_tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned PRE_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             dflt_i,
  input  logic             start_i,
  output logic [CNT_W-1:0] limit_o
);
  localparam int unsigned N_MODES = 2;

  logic [CNT_W-1:0] def_tbl [N_MODES];
  logic [CNT_W-1:0] user_q;
  logic             use_dflt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_next;

  for (genvar m = 0; m < N_MODES; m++) begin : g_def
    localparam int unsigned US = (m == int'(MODE_BASEX)) ? BASEX_US : SGMII_US;
    assign def_tbl[m] = CNT_W'(dflt_ticks(US, CLK_MHZ, PRE_W));
  end

  always_comb begin
    if (use_dflt_q) lim_next = def_tbl[mode_i];
    else            lim_next = user_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      user_q     <= '0;
      use_dflt_q <= 1'b1;
    end else if (wr_i) begin
      user_q     <= wdata_i;
      use_dflt_q <= 1'b0;
    end else if (dflt_i) begin
      use_dflt_q <= 1'b1;
    end
  end

  // active limit frozen for the whole run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lim_q <= '0;
    else if (start_i) lim_q <= lim_next;
  end

  assign limit_o = lim_q;
endmodule

// File: rtl/an_tmr_counter.sv
module an_tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o,
  output logic             running_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             exp_q;
  logic [CNT_W:0]   cnt_inc;
  logic             hit;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign hit     = cnt_inc >= {1'b0, limit_i};  // limit 0 hits on first tick

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (run_q && tick_i) begin
        if (hit) begin
          cnt_q <= '0;
          run_q <= 1'b0;
          exp_q <= 1'b1;
        end else begin
          cnt_q <= cnt_inc[CNT_W-1:0];
        end
      end
    end
  end

  assign expire_o  = exp_q;
  assign running_o = run_q;
endmodule

// File: rtl/an_link_timer.sv
module an_link_timer #(
  parameter int unsigned CLK_MHZ    = 125,
  parameter int unsigned PRESCALE_W = 10,
  parameter int unsigned CNT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             dflt_sel_i,
  input  logic             start_i,
  output logic             expire_o,
  output logic             running_o
);
  logic             tick;
  logic [CNT_W-1:0] limit;

  an_tmr_prescale #(.PRE_W(PRESCALE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .tick_o (tick)
  );

  an_tmr_limit #(.CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ), .PRE_W(PRESCALE_W)) u_lim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .wr_i    (cnt_wr_i),
    .wdata_i (cnt_wdata_i),
    .dflt_i  (dflt_sel_i),
    .start_i (start_i),
    .limit_o (limit)
  );

  an_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .tick_i    (tick),
    .limit_i   (limit),
    .expire_o  (expire_o),
    .running_o (running_o)
  );
endmodule

// File: rtl/an_link_timer_chk.sv
module an_link_timer_chk #(
  parameter int unsigned PRE_W = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic expire_o,
  input logic running_o
);
  logic [31:0] since_q;

  // cycles since the edge that sampled the last start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_q <= '0;
    else if (start_i)         since_q <= '0;
    else if (~&since_q)       since_q <= since_q + 32'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!expire_o && !running_o));

  p_start_runs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> running_o);

  p_start_no_expire_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !expire_o);

  p_expire_grid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (since_q != 32'd0 && since_q[PRE_W-1:0] == '0));

  p_expire_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);

  p_expire_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !running_o);

  p_expire_after_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(running_o));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !start_i) |=> !running_o);
endmodule

bind an_link_timer an_link_timer_chk #(.PRE_W(PRESCALE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .expire_o  (expire_o),
  .running_o (running_o)
);

// File: tb/tb_an_link_timer.sv
module tb_an_link_timer;
  localparam int MHZ  = 4;
  localparam int CW   = 16;
  localparam int TICK = 1024;
  localparam int DX   = (10000 * MHZ) >> 10;  // 39
  localparam int DS   = (1600 * MHZ) >> 10;   // 6

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_i = 1'b0;
  logic          cnt_wr_i = 1'b0;
  logic [CW-1:0] cnt_wdata_i = '0;
  logic          dflt_sel_i = 1'b0;
  logic          start_i = 1'b0;
  logic          expire_o, running_o;

  int errors = 0, checks = 0, n_exp = 0;
  bit done = 0;

  // model state
  bit m_run = 0, m_exp = 0, m_def = 1;
  int m_reg = 0, m_act = 0, m_cyc = 0;

  always #4 clk_i = ~clk_i;

  an_link_timer #(.CLK_MHZ(MHZ), .PRESCALE_W(10), .CNT_W(CW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .cnt_wr_i(cnt_wr_i),
    .cnt_wdata_i(cnt_wdata_i), .dflt_sel_i(dflt_sel_i), .start_i(start_i),
    .expire_o(expire_o), .running_o(running_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_exp = 0; m_def = 1; m_reg = 0; m_act = 0; m_cyc = 0;
    end else begin
      m_exp = 0;
      if (start_i) begin
        m_act = m_def ? (mode_i ? DX : DS) : m_reg;
        m_run = 1; m_cyc = 0;
      end else if (m_run) begin
        m_cyc++;
        if (m_cyc == TICK * ((m_act == 0) ? 1 : m_act)) begin
          m_exp = 1; m_run = 0;
        end
      end
      if (cnt_wr_i) begin m_reg = int'(cnt_wdata_i); m_def = 0; end
      else if (dflt_sel_i) m_def = 1;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk(expire_o == m_exp, "R4 expire vs model", int'(expire_o), int'(m_exp));
      chk(running_o == m_run, "R6 running vs model", int'(running_o), int'(m_run));
      if (expire_o) n_exp++;
    end
  end

  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic write_cnt(input int v);
    @(negedge clk_i) begin cnt_wr_i = 1'b1; cnt_wdata_i = CW'(v); end
    @(negedge clk_i) cnt_wr_i = 1'b0;
  endtask

  task automatic wait_expire(input int k0, output int k);
    k = k0;
    while (!expire_o && k < 60000) begin
      @(negedge clk_i);
      k++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k, e0;
    repeat (3) @(negedge clk_i);
    chk(!expire_o && !running_o, "R1 in reset", int'({expire_o, running_o}), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(!expire_o && !running_o, "R1 after reset", int'({expire_o, running_o}), 0);

    // R2 default 1000BASE-X
    mode_i = 1'b1;
    pulse_start();
    chk(running_o, "R5 running after start", int'(running_o), 1);
    wait_expire(0, k);
    chk(k == TICK * DX, "R2 basex default interval", k, TICK * DX);
    @(negedge clk_i);
    chk(!expire_o && !running_o, "R6 single pulse, idle", int'({expire_o, running_o}), 0);
    e0 = n_exp;
    repeat (3000) @(negedge clk_i);
    chk(n_exp == e0 && !running_o, "R6 no re-expiry without start", n_exp, e0);

    // R3 default SGMII
    mode_i = 1'b0;
    pulse_start();
    wait_expire(0, k);
    chk(k == TICK * DS, "R3 sgmii default interval", k, TICK * DS);

    // R7 zero count
    write_cnt(0);
    pulse_start();
    wait_expire(0, k);
    chk(k == TICK, "R7 zero count expires on first tick", k, TICK);

    // R8 mid-run write and mode change held off
    write_cnt(3);
    pulse_start();
    repeat (500) @(negedge clk_i);
    cnt_wr_i = 1'b1; cnt_wdata_i = CW'(10); mode_i = 1'b1;
    @(negedge clk_i) cnt_wr_i = 1'b0;
    wait_expire(501, k);
    chk(k == TICK * 3, "R8 running interval unchanged", k, TICK * 3);
    pulse_start();
    wait_expire(0, k);
    chk(k == TICK * 10, "R8 new count at next start", k, TICK * 10);

    // R9 write beats default select on same edge, then default again
    mode_i = 1'b0;
    @(negedge clk_i) begin cnt_wr_i = 1'b1; dflt_sel_i = 1'b1; cnt_wdata_i = CW'(2); end
    @(negedge clk_i) begin cnt_wr_i = 1'b0; dflt_sel_i = 1'b0; end
    pulse_start();
    wait_expire(0, k);
    chk(k == TICK * 2, "R9 write wins over default select", k, TICK * 2);
    @(negedge clk_i) dflt_sel_i = 1'b1;
    @(negedge clk_i) dflt_sel_i = 1'b0;
    pulse_start();
    wait_expire(0, k);
    chk(k == TICK * DS, "R9 default selected again", k, TICK * DS);

    // R10 restart on the expiry edge
    write_cnt(1);
    pulse_start();
    e0 = n_exp;
    repeat (1023) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk(!expire_o && running_o && n_exp == e0, "R10 start suppresses expiry",
        int'({expire_o, running_o}), 1);
    wait_expire(0, k);
    chk(k == TICK, "R10 full interval after restart", k, TICK);

    repeat (10) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule